// File: doc/BRIEF.md
# Thread Block Admission Controller

This block decides when the pending thread blocks of a kernel launch may become resident on one streaming multiprocessor. Each launch request names a thread count and a per-thread register demand. The block rejects requests that could never fit. It places the rest in a short in-order wait queue. The head of that queue is offered on the dispatch port only when all four shared resources can take it together: a free block slot, enough thread slots, enough warp slots and a contiguous run of free register chunks.

Resources are partitioned dynamically rather than in fixed per-block shares. Small blocks can therefore fill the slot table, and large blocks can claim most of the register pool. When a resident block retires, a completion pulse names its slot. That slot's threads, warps and register chunks return to the pools in the same clock edge, so a waiting block can be admitted on the following cycle. A resident-warp counter reports occupancy as a fraction of the 64-warp capacity.

Top module: `tblk_admit`

## Requirements
- R1: After reset, launch_ready is 1, disp_valid is 0 and occ_warps is 0.
- R2: A launch with 0 threads, more than 1024 threads, 0 registers per thread, or a register total (threads times registers) above 65536 raises launch_reject in the same cycle and is not queued.
- R3: The warp demand of a block is its thread count divided by 32, rounded up. It is shown on disp_warps.
- R4: At most 32 blocks are resident. With 32-thread blocks, occupancy stops at 32 warps (50%).
- R5: Resident threads never exceed 2048 and resident warps never exceed 64. A block that would exceed either limit waits.
- R6: Registers are granted in chunks of 256. A block needs ceil(threads*regs/256) chunks, taken as the lowest-addressed contiguous run of free chunks. disp_reg_base is the first chunk index times 256. A block that finds no such run waits.
- R7: Queued blocks are dispatched strictly in arrival order. A head block that does not fit holds back every block behind it.
- R8: A completion naming a resident slot frees all of that slot's resources at that edge, and a waiting block that now fits is offered on the next cycle. A completion naming an idle slot has no effect.
- R9: While disp_valid is 1 and disp_ready is 0, the offered block stays offered with unchanged thread and warp counts. At most one block is dispatched per cycle.
- R10: occ_warps equals the sum of the warp demands of the resident blocks, in the range 0 to 64.
- R11: The wait queue holds 4 blocks. launch_ready is 0 exactly when it is full.
- R12: A dispatched block receives the lowest-numbered free slot as disp_id, and that ID is later used on comp_id.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| launch_valid | input | 1 | Launch request present |
| launch_ready | output | 1 | Wait queue can accept a request |
| launch_threads | input | 12 | Threads in the requested block |
| launch_regs | input | 8 | Registers needed per thread |
| launch_reject | output | 1 | Request accepted but refused as unfittable |
| disp_valid | output | 1 | Head block fits and is offered |
| disp_ready | input | 1 | Consumer takes the offered block |
| disp_id | output | 5 | Slot assigned to the offered block |
| disp_threads | output | 11 | Thread count of the offered block |
| disp_warps | output | 7 | Warp demand of the offered block |
| disp_reg_base | output | 16 | First register of the granted range |
| comp_valid | input | 1 | A resident block has finished |
| comp_id | input | 5 | Slot of the finished block |
| occ_warps | output | 7 | Resident warps (occupancy numerator over 64) |

## Verification
Four limits are checked by assertions on every cycle: the block, thread and warp counts stay within their limits, a granted register run stays inside the pool, and an offer stalled by backpressure stays unchanged. Other cycle-by-cycle assertions check that a rejected launch never grows the queue, that a completion lowers occupancy, and that a dispatch raises it. The bench scenarios are needed for the rest: first-fit placement around holes, in-order stalling behind a blocked head block, lowest-slot selection, the one-cycle gap between a completion and the admission it enables, and a completion aimed at an idle slot being ignored.

// File: rtl/tblk_admit.sv
module tblk_admit #(
  parameter int MAX_BLOCKS     = 32,
  parameter int MAX_THREADS    = 2048,
  parameter int BLK_THREAD_MAX = 1024,
  parameter int WARP           = 32,
  parameter int REG_POOL       = 65536,
  parameter int CHUNK          = 256,
  parameter int QDEPTH         = 4,
  parameter int RPT_W          = 8
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic                                  launch_valid,
  output logic                                  launch_ready,
  input  logic [$clog2(BLK_THREAD_MAX+1):0]     launch_threads,
  input  logic [RPT_W-1:0]                      launch_regs,
  output logic                                  launch_reject,
  output logic                                  disp_valid,
  input  logic                                  disp_ready,
  output logic [$clog2(MAX_BLOCKS)-1:0]         disp_id,
  output logic [$clog2(BLK_THREAD_MAX+1)-1:0]   disp_threads,
  output logic [$clog2(MAX_THREADS/WARP+1)-1:0] disp_warps,
  output logic [$clog2(REG_POOL)-1:0]           disp_reg_base,
  input  logic                                  comp_valid,
  input  logic [$clog2(MAX_BLOCKS)-1:0]         comp_id,
  output logic [$clog2(MAX_THREADS/WARP+1)-1:0] occ_warps
);
  localparam int NCH  = REG_POOL / CHUNK;
  localparam int MAXW = MAX_THREADS / WARP;
  localparam int IW   = $clog2(MAX_BLOCKS);
  localparam int TW   = $clog2(BLK_THREAD_MAX + 1);
  localparam int LTW  = TW + 1;
  localparam int OW   = $clog2(MAXW + 1);
  localparam int UW   = $clog2(MAX_THREADS + 1);
  localparam int BW   = $clog2(MAX_BLOCKS + 1);
  localparam int CIW  = $clog2(NCH);
  localparam int NW   = $clog2(NCH + 1);
  localparam int RBW  = $clog2(REG_POOL);
  localparam int CSH  = $clog2(CHUNK);
  localparam int WSH  = $clog2(WARP);
  localparam int QW   = $clog2(QDEPTH);
  localparam int PW   = LTW + RPT_W;
  localparam int HPW  = TW + RPT_W;

  logic [TW-1:0]    q_thr [QDEPTH];
  logic [RPT_W-1:0] q_rpt [QDEPTH];
  logic [QW-1:0]    q_rd, q_wr;
  logic [QW:0]      q_cnt;

  logic             s_busy [MAX_BLOCKS];
  logic [TW-1:0]    s_thr  [MAX_BLOCKS];
  logic [OW-1:0]    s_w    [MAX_BLOCKS];
  logic [CIW-1:0]   s_base [MAX_BLOCKS];
  logic [NW-1:0]    s_n    [MAX_BLOCKS];
  logic [NCH-1:0]   chunk_free;
  logic [UW-1:0]    thr_used;
  logic [OW-1:0]    warps_used;
  logic [BW-1:0]    blk_cnt;

  logic [PW-1:0]    l_prod;
  logic             l_bad, push, fire, comp_hit, h_vld;
  logic [TW-1:0]    h_thr, h_warps;
  logic [RPT_W-1:0] h_rpt;
  logic [HPW-1:0]   h_need;
  logic             sl_ok, ff_ok, res_ok;
  logic [IW-1:0]    sl_id;
  logic [CIW-1:0]   ff_base;
  logic [NW-1:0]    run;

  assign l_prod        = PW'(launch_threads) * PW'(launch_regs);
  assign l_bad         = (launch_threads == '0) || (launch_threads > LTW'(BLK_THREAD_MAX)) ||
                         (launch_regs == '0) || (l_prod > PW'(REG_POOL));
  assign launch_ready  = (q_cnt != (QW+1)'(QDEPTH));
  assign push          = launch_valid && launch_ready && !l_bad;
  assign launch_reject = launch_valid && launch_ready && l_bad;

  assign h_vld   = (q_cnt != '0);
  assign h_thr   = q_thr[q_rd];
  assign h_rpt   = q_rpt[q_rd];
  assign h_warps = (h_thr + TW'(WARP - 1)) >> WSH;
  assign h_need  = (HPW'(h_thr) * HPW'(h_rpt) + HPW'(CHUNK - 1)) >> CSH;

  always_comb begin
    sl_ok = 1'b0;
    sl_id = '0;
    for (int s = 0; s < MAX_BLOCKS; s++)
      if (!sl_ok && !s_busy[s]) begin
        sl_ok = 1'b1;
        sl_id = IW'(s);
      end
  end

  always_comb begin
    run     = '0;
    ff_ok   = 1'b0;
    ff_base = '0;
    for (int i = 0; i < NCH; i++) begin
      if (chunk_free[i]) run = run + 1'b1;
      else               run = '0;
      if (!ff_ok && HPW'(run) == h_need) begin
        ff_ok   = 1'b1;
        ff_base = CIW'(i + 1 - int'(run));
      end
    end
  end

  assign res_ok = ((UW+1)'(thr_used) + (UW+1)'(h_thr) <= (UW+1)'(MAX_THREADS)) &&
                  ((OW+1)'(warps_used) + (OW+1)'(h_warps) <= (OW+1)'(MAXW));

  assign disp_valid    = h_vld && sl_ok && ff_ok && res_ok;
  assign fire          = disp_valid && disp_ready;
  assign comp_hit      = comp_valid && s_busy[comp_id];
  assign disp_id       = sl_id;
  assign disp_threads  = h_thr;
  assign disp_warps    = OW'(h_warps);
  assign disp_reg_base = RBW'(ff_base) << CSH;
  assign occ_warps     = warps_used;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q_rd <= '0;
      q_wr <= '0;
      q_cnt <= '0;
      for (int k = 0; k < QDEPTH; k++) begin
        q_thr[k] <= '0;
        q_rpt[k] <= '0;
      end
    end else begin
      if (push) begin
        q_thr[q_wr] <= TW'(launch_threads);
        q_rpt[q_wr] <= launch_regs;
        q_wr <= q_wr + 1'b1;
      end
      if (fire) q_rd <= q_rd + 1'b1;
      q_cnt <= q_cnt + (QW+1)'(push) - (QW+1)'(fire);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < MAX_BLOCKS; s++) begin
        s_busy[s] <= 1'b0;
        s_thr[s]  <= '0;
        s_w[s]    <= '0;
        s_base[s] <= '0;
        s_n[s]    <= '0;
      end
      chunk_free <= '1;
      thr_used   <= '0;
      warps_used <= '0;
      blk_cnt    <= '0;
    end else begin
      for (int s = 0; s < MAX_BLOCKS; s++) begin
        if (comp_hit && comp_id == IW'(s)) s_busy[s] <= 1'b0;
        if (fire && sl_id == IW'(s)) begin
          s_busy[s] <= 1'b1;
          s_thr[s]  <= h_thr;
          s_w[s]    <= OW'(h_warps);
          s_base[s] <= ff_base;
          s_n[s]    <= NW'(h_need);
        end
      end
      for (int i = 0; i < NCH; i++) begin
        if (comp_hit && i >= int'(s_base[comp_id]) && i < int'(s_base[comp_id]) + int'(s_n[comp_id]))
          chunk_free[i] <= 1'b1;
        if (fire && i >= int'(ff_base) && i < int'(ff_base) + int'(h_need))
          chunk_free[i] <= 1'b0;
      end
      thr_used   <= thr_used + (fire ? UW'(h_thr) : '0) - (comp_hit ? UW'(s_thr[comp_id]) : '0);
      warps_used <= warps_used + (fire ? OW'(h_warps) : '0) - (comp_hit ? s_w[comp_id] : '0);
      blk_cnt    <= blk_cnt + BW'(fire) - BW'(comp_hit);
    end
  end

  assert_blk_cap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    blk_cnt <= BW'(MAX_BLOCKS));
  assert_thread_warp_cap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    thr_used <= UW'(MAX_THREADS) && warps_used <= OW'(MAXW));
  assert_run_in_pool_R6: assert property (@(posedge clk) disable iff (!rst_n)
    disp_valid |-> int'(ff_base) + int'(h_need) <= NCH);
  assert_reject_no_queue_R2: assert property (@(posedge clk) disable iff (!rst_n)
    launch_reject |=> q_cnt <= $past(q_cnt));
  assert_free_lowers_occ_R8: assert property (@(posedge clk) disable iff (!rst_n)
    comp_hit && !fire |=> occ_warps < $past(occ_warps));
  assert_admit_raises_occ_R10: assert property (@(posedge clk) disable iff (!rst_n)
    fire && !comp_hit |=> occ_warps > $past(occ_warps));
  assert_hold_offer_R9: assert property (@(posedge clk) disable iff (!rst_n)
    disp_valid && !disp_ready |=> disp_valid && $stable(disp_threads) && $stable(disp_warps));
endmodule

// File: tb/tblk_admit_bench.sv
`timescale 1ns/1ps
module tblk_admit_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic launch_valid = 0, disp_ready = 0, comp_valid = 0;
  logic [11:0] launch_threads = '0;
  logic [7:0]  launch_regs = '0;
  logic [4:0]  comp_id = '0;
  logic launch_ready, launch_reject, disp_valid;
  logic [4:0]  disp_id;
  logic [10:0] disp_threads;
  logic [6:0]  disp_warps, occ_warps;
  logic [15:0] disp_reg_base;

  tblk_admit u_tblk_admit (.*);

  always #10 clk = ~clk;

  int n_chk = 0, n_bad = 0;
  int mq_t[$], mq_r[$];
  bit m_busy[32];
  int m_thr[32], m_w[32], m_base[32], m_n[32];
  bit m_free[256];
  int m_tu = 0, m_wu = 0;

  task automatic chk(input string what, input longint act, input longint exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", what, act, exp);
    end
  endtask

  function automatic bit is_bad(int t, int r);
    return t == 0 || t > 1024 || r == 0 || t * r > 65536;
  endfunction

  function automatic int first_fit(int need);
    for (int s = 0; s + need <= 256; s++) begin
      bit ok = 1;
      for (int j = s; j < s + need; j++) if (!m_free[j]) ok = 0;
      if (ok) return s;
    end
    return -1;
  endfunction

  task automatic step(int lv, int lt, int lr, int dr, int cv, int cid);
    int ht, hw, hn, slot, base;
    bit e_ready, e_rej, e_valid, hit;
    launch_valid = lv[0]; launch_threads = 12'(lt); launch_regs = 8'(lr);
    disp_ready = dr[0]; comp_valid = cv[0]; comp_id = 5'(cid);
    #1;
    e_ready = mq_t.size() < 4;
    e_rej = lv != 0 && e_ready && is_bad(lt, lr);
    e_valid = 0; slot = -1; base = -1; ht = 0; hw = 0; hn = 0;
    if (mq_t.size() > 0) begin
      ht = mq_t[0]; hw = (ht + 31) / 32; hn = (ht * mq_r[0] + 255) / 256;
      for (int s = 31; s >= 0; s--) if (!m_busy[s]) slot = s;
      base = first_fit(hn);
      e_valid = slot >= 0 && base >= 0 && m_tu + ht <= 2048 && m_wu + hw <= 64;
    end
    chk("R11 launch_ready", launch_ready, e_ready);
    chk("R2 launch_reject", launch_reject, e_rej);
    chk("R7 disp_valid", disp_valid, e_valid);
    chk("R10 occ_warps", occ_warps, m_wu);
    if (e_valid) begin
      chk("R12 disp_id", disp_id, slot);
      chk("R7 disp_threads", disp_threads, ht);
      chk("R3 disp_warps", disp_warps, hw);
      chk("R6 disp_reg_base", disp_reg_base, base * 256);
    end
    hit = cv != 0 && m_busy[cid];
    if (hit) begin
      m_busy[cid] = 0; m_tu -= m_thr[cid]; m_wu -= m_w[cid];
      for (int j = m_base[cid]; j < m_base[cid] + m_n[cid]; j++) m_free[j] = 1;
    end
    if (e_valid && dr != 0) begin
      m_busy[slot] = 1; m_thr[slot] = ht; m_w[slot] = hw; m_base[slot] = base; m_n[slot] = hn;
      m_tu += ht; m_wu += hw;
      for (int j = base; j < base + hn; j++) m_free[j] = 0;
      void'(mq_t.pop_front()); void'(mq_r.pop_front());
    end
    if (lv != 0 && e_ready && !e_rej) begin mq_t.push_back(lt); mq_r.push_back(lr); end
    @(negedge clk);
  endtask

  task automatic idle(int n, int dr);
    for (int i = 0; i < n; i++) step(0, 0, 0, dr, 0, 0);
  endtask

  task automatic drain();
    for (int k = 0; k < 400; k++) begin
      int c = -1;
      for (int s = 31; s >= 0; s--) if (m_busy[s]) c = s;
      if (c < 0 && mq_t.size() == 0) break;
      step(0, 0, 0, 1, c >= 0, c >= 0 ? c : 0);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog R9: actual hung expected finished");
    summary();
    $finish;
  end

  initial begin
    int v0, v1;
    void'($urandom(32'd4242));
    for (int j = 0; j < 256; j++) m_free[j] = 1;
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    chk("R1 reset launch_ready", launch_ready, 1);
    chk("R1 reset disp_valid", disp_valid, 0);
    chk("R1 reset occ_warps", occ_warps, 0);

    // R2 rejections
    step(1, 1025, 1, 0, 0, 0);
    step(1, 0, 4, 0, 0, 0);
    step(1, 64, 0, 0, 0, 0);
    step(1, 1024, 255, 0, 0, 0);
    chk("R2 nothing queued", disp_valid, 0);

    // R4 block-slot cap with 32-thread blocks
    for (int i = 0; i < 40; i++) step(1, 32, 1, 1, 0, 0);
    idle(8, 1);
    chk("R4 occupancy capped at 32 warps", occ_warps, 32);
    chk("R4 no slot, head waits", disp_valid, 0);
    step(0, 0, 0, 0, 1, 5);
    chk("R8 admit next cycle after completion", disp_valid, 1);
    chk("R12 freed slot reused", disp_id, 5);
    step(0, 0, 0, 0, 1, 5);
    chk("R8 completion of idle slot ignored", occ_warps, 31);
    drain();

    // R6 whole pool taken by 1024 x 64
    step(1, 1024, 64, 1, 0, 0);
    step(1, 32, 1, 1, 0, 0);
    idle(2, 1);
    chk("R6 pool exhausted, small block waits", disp_valid, 0);
    chk("R3 1024 threads give 32 warps", occ_warps, 32);
    step(0, 0, 0, 1, 1, 0);
    chk("R6 reuse of base 0", disp_reg_base, 0);
    drain();

    // R5 warp limit and R7 head blocking
    for (int i = 0; i < 3; i++) step(1, 1024, 16, 1, 0, 0);
    step(1, 32, 1, 1, 0, 0);
    idle(3, 1);
    chk("R5 third large block waits on warps", disp_valid, 0);
    chk("R7 small block held behind head", occ_warps, 64);
    drain();

    // R6 first fit around a hole
    for (int i = 0; i < 3; i++) step(1, 32, 64, 1, 0, 0);
    idle(1, 1);
    step(0, 0, 0, 0, 1, 1);
    step(1, 32, 128, 0, 0, 0);
    step(1, 32, 64, 0, 0, 0);
    chk("R6 hole too small, run after it", disp_reg_base, 24 * 256);
    step(0, 0, 0, 1, 0, 0);
    chk("R6 later block fills hole", disp_reg_base, 8 * 256);
    drain();

    // R9 backpressure and R11 full queue
    for (int i = 0; i < 5; i++) step(1, 100, 3, 0, 0, 0);
    chk("R11 queue full", launch_ready, 0);
    v0 = disp_id; v1 = disp_threads;
    idle(3, 0);
    chk("R9 offer held", disp_valid, 1);
    chk("R9 id held", disp_id, v0);
    chk("R9 threads held", disp_threads, v1);
    drain();

    // random mix
    for (int i = 0; i < 5000; i++) begin
      int lt, lr, cv, cid, sel;
      sel = $urandom % 10;
      case (sel)
        0: lt = 1025 + $urandom % 200;
        1: lt = 1024;
        2: lt = 32;
        3: lt = 512;
        default: lt = 1 + $urandom % 1024;
      endcase
      lr = ($urandom % 20 == 0) ? 0 : 1 + $urandom % 72;
      cv = ($urandom % 3 == 0);
      cid = $urandom % 32;
      if (cv != 0 && $urandom % 5 != 0)
        for (int k = 0; k < 32; k++) if (m_busy[(cid + k) % 32]) begin cid = (cid + k) % 32; break; end
      step(($urandom % 3) != 0, lt, lr, ($urandom % 4) != 0, cv, cid);
    end
    drain();
    chk("R10 empty at end", occ_warps, 0);
    summary();
    $finish;
  end
endmodule